// File: doc/BRIEF.md
# Flash command sequence decoder

This block models the command interface of a byte-wide parallel flash device. Each bus write brings an address and a data byte. The block follows those writes through the fixed unlock sequences. When a sequence completes, it issues one of four requests to the embedded-operation engine: program a byte, erase the whole array, erase one sector, or set the boot-region lock. Each request is a single-cycle pulse. It carries the address and data of the final write, and for a sector erase also the index of the sector that holds that address.

Two shorter sequences switch the read path between the memory array and a small identifier space. The identifier space holds the maker code, the device code and the lock state. Several conditions return the block to plain array reads: a write that does not fit the expected sequence, and the completion of any launched command. The engine raises a busy flag while an operation runs, and writes seen during that time are dropped. Once the lock is set, it survives everything except the reset input, and sector erases aimed at the boot region are refused from then on.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Directly after reset there are no request pulses, identifier mode is off, the lock is clear, and rd_data equals array_rdata.
- R2: Four writes start a byte program: 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555, then the target. The cycle after the fourth write, prog_req pulses and req_addr/req_data hold the target write. Only the low 15 address bits take part in the unlock compares.
- R3: Six writes start a chip erase: the unlock pair, 0x80 at 0x5555, the unlock pair again, then 0x10 at 0x5555. chip_erase_req pulses the cycle after the sixth write.
- R4: A sector erase uses the same five-write prefix and ends with 0x30 at any address. sector_erase_req pulses and req_addr holds that address. req_sector encodes the sector as 0 for 0x00000–0x1FFFF, 1 for 0x20000–0x37FFF, 2 for 0x38000–0x39FFF, 3 for 0x3A000–0x3BFFF and 4 for 0x3C000–0x3FFFF.
- R5: The same five-write prefix followed by 0x40 at 0x5555 pulses lock_req and sets lock_status in the same cycle. Only reset clears lock_status.
- R6: While lock_status is 1, a sector erase whose address lies in sector 4 produces no pulse and returns the decoder to idle.
- R7: The unlock pair followed by 0x90 at 0x5555 turns on id_mode. In id_mode, rd_data depends on rd_offset: 0 returns 0xDA, 1 returns the device code (default 0x0B), 2 returns {7'b0, lock_status}, and 3 returns 0x00.
- R8: id_mode turns off on a single 0xF0 write to any address. It also turns off on the unlock pair followed by 0xF0 at 0x5555, and whenever a program, erase or lock request is issued.
- R9: A write that breaks a sequence, by wrong address, wrong data or wrong order, returns the decoder to idle and turns id_mode off. A later write that would have completed the broken sequence issues nothing.
- R10: While busy is 1, writes are ignored. They issue no request, and a sequence in progress resumes with the next non-busy write.
- R11: At most one request pulse is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears sequence, id mode and lock |
| wr_en | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Embedded operation in progress |
| rd_offset | input | 2 | Low two bits of the read address |
| array_rdata | input | 8 | Byte read from the memory array |
| rd_data | output | 8 | Byte returned to the reader |
| prog_req | output | 1 | Byte program request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sector_erase_req | output | 1 | Sector erase request pulse |
| lock_req | output | 1 | Boot lock enable request pulse |
| req_addr | output | 18 | Address of the final write of the last request |
| req_data | output | 8 | Data of the final write of the last request |
| req_sector | output | 3 | Sector index of req_addr |
| id_mode | output | 1 | Read path shows identifier bytes |
| lock_status | output | 1 | Boot region lock is set |

## Verification
Several properties are checked on every cycle: only one pulse at a time and no two-cycle pulses, the freeze of the sequence state under busy or idle write strobes, the stickiness of the lock, the refusal of a boot-sector erase under lock, id mode off on every launch, and the reset state. Other behaviour depends on exact address and data values and can only be shown by the bench's scenarios. This covers whether the right sequence launches the right request, the latched address, data and sector, the identifier bytes, both exit paths, and mismatches that abort a partial sequence. A reference model in the bench tracks these through directed cases and a long randomized run with corrupted and busy-masked writes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;
    localparam int CMP_W  = 15;
    localparam int SECT_W = 3;
    localparam int N_REQ  = 4;

    localparam logic [CMP_W-1:0] UNLK_A = 15'h5555;
    localparam logic [CMP_W-1:0] UNLK_B = 15'h2AAA;

    localparam logic [DATA_W-1:0] K_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] K_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] K_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] K_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] K_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] K_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] K_LOCK   = 8'h40;
    localparam logic [DATA_W-1:0] K_IDIN   = 8'h90;
    localparam logic [DATA_W-1:0] K_IDOUT  = 8'hF0;

    localparam logic [ADDR_W-1:0] BASE_S1 = 18'h20000;
    localparam logic [ADDR_W-1:0] BASE_S2 = 18'h38000;
    localparam logic [ADDR_W-1:0] BASE_S3 = 18'h3A000;
    localparam logic [ADDR_W-1:0] BASE_S4 = 18'h3C000;
    localparam logic [SECT_W-1:0] SEC_BOOT = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_U1, ST_U2, ST_PROG, ST_E3, ST_E4, ST_E5
    } seq_state_e;

    typedef enum logic [2:0] {
        EV_NONE, EV_PROG, EV_CHIP, EV_SECT, EV_LOCK, EV_ID_IN, EV_ID_OUT, EV_ABORT
    } cmd_ev_e;

    function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
        if (a >= BASE_S4)      return 3'd4;
        else if (a >= BASE_S3) return 3'd3;
        else if (a >= BASE_S2) return 3'd2;
        else if (a >= BASE_S1) return 3'd1;
        else                   return 3'd0;
    endfunction

    // pulse bit order: 0 program, 1 chip erase, 2 sector erase, 3 lock
    function automatic cmd_ev_e pulse_kind(input int unsigned idx);
        case (idx)
            0:       return EV_PROG;
            1:       return EV_CHIP;
            2:       return EV_SECT;
            default: return EV_LOCK;
        endcase
    endfunction

    function automatic logic is_launch(input cmd_ev_e ev);
        return (ev == EV_PROG) || (ev == EV_CHIP) || (ev == EV_SECT) || (ev == EV_LOCK);
    endfunction

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock_q,
    output seq_state_e        state,
    output cmd_ev_e           cmd_ev
);

    seq_state_e       nxt;
    logic [CMP_W-1:0] cmp_a;
    logic             hit_a;
    logic             hit_b;
    logic             boot_hit;

    assign cmp_a    = wr_addr[CMP_W-1:0];
    assign hit_a    = (cmp_a == UNLK_A);
    assign hit_b    = (cmp_a == UNLK_B);
    assign boot_hit = (sector_of(wr_addr) == SEC_BOOT);

    always_comb begin
        nxt    = state;
        cmd_ev = EV_NONE;
        if (wr_en && !busy) begin
            nxt    = ST_IDLE;
            cmd_ev = EV_ABORT;
            case (state)
                ST_IDLE: if (hit_a && wr_data == K_FIRST) begin
                    nxt = ST_U1; cmd_ev = EV_NONE;
                end
                ST_U1: if (hit_b && wr_data == K_SECOND) begin
                    nxt = ST_U2; cmd_ev = EV_NONE;
                end
                ST_U2: if (hit_a) begin
                    case (wr_data)
                        K_PROG:  begin nxt = ST_PROG; cmd_ev = EV_NONE; end
                        K_ERASE: begin nxt = ST_E3;   cmd_ev = EV_NONE; end
                        K_IDIN:  cmd_ev = EV_ID_IN;
                        K_IDOUT: cmd_ev = EV_ID_OUT;
                        default: cmd_ev = EV_ABORT;
                    endcase
                end
                ST_PROG: cmd_ev = EV_PROG;
                ST_E3: if (hit_a && wr_data == K_FIRST) begin
                    nxt = ST_E4; cmd_ev = EV_NONE;
                end
                ST_E4: if (hit_b && wr_data == K_SECOND) begin
                    nxt = ST_E5; cmd_ev = EV_NONE;
                end
                ST_E5: begin
                    if (wr_data == K_SECT) begin
                        if (!(boot_hit && lock_q)) cmd_ev = EV_SECT;
                    end else if (hit_a && wr_data == K_CHIP) begin
                        cmd_ev = EV_CHIP;
                    end else if (hit_a && wr_data == K_LOCK) begin
                        cmd_ev = EV_LOCK;
                    end
                end
                default: cmd_ev = EV_ABORT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/fcd_req_reg.sv
module fcd_req_reg
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_ev_e           cmd_ev,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_REQ-1:0]  pulse_q,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [SECT_W-1:0] req_sector,
    output logic              lock_q,
    output logic              id_q
);

    for (genvar g = 0; g < N_REQ; g++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (rst) pulse_q[g] <= 1'b0;
            else     pulse_q[g] <= (cmd_ev == pulse_kind(g));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_addr   <= '0;
            req_data   <= '0;
            req_sector <= '0;
        end else if (is_launch(cmd_ev)) begin
            req_addr   <= wr_addr;
            req_data   <= wr_data;
            req_sector <= sector_of(wr_addr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            id_q   <= 1'b0;
        end else begin
            if (cmd_ev == EV_LOCK) lock_q <= 1'b1;
            case (cmd_ev)
                EV_NONE:  id_q <= id_q;
                EV_ID_IN: id_q <= 1'b1;
                default:  id_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
    import flash_cmd_pkg::*;
#(
    parameter logic [DATA_W-1:0] MFR_ID = 8'hDA,
    parameter logic [DATA_W-1:0] DEV_ID = 8'h0B
) (
    input  logic              id_mode,
    input  logic              lock_q,
    input  logic [1:0]        rd_offset,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        if (!id_mode) begin
            rd_data = array_rdata;
        end else begin
            case (rd_offset)
                2'd0:    rd_data = MFR_ID;
                2'd1:    rd_data = DEV_ID;
                2'd2:    rd_data = {{(DATA_W-1){1'b0}}, lock_q};
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter logic [DATA_W-1:0] MFR_ID = 8'hDA,
    parameter logic [DATA_W-1:0] DEV_ID = 8'h0B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [1:0]        rd_offset,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              prog_req,
    output logic              chip_erase_req,
    output logic              sector_erase_req,
    output logic              lock_req,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [SECT_W-1:0] req_sector,
    output logic              id_mode,
    output logic              lock_status
);

    seq_state_e       seq_state;
    cmd_ev_e          cmd_ev;
    logic [N_REQ-1:0] pulse_q;

    fcd_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .busy    (busy),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lock_q  (lock_status),
        .state   (seq_state),
        .cmd_ev  (cmd_ev)
    );

    fcd_req_reg u_req (
        .clk        (clk),
        .rst        (rst),
        .cmd_ev     (cmd_ev),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pulse_q    (pulse_q),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_sector (req_sector),
        .lock_q     (lock_status),
        .id_q       (id_mode)
    );

    fcd_read_mux #(
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_rd (
        .id_mode     (id_mode),
        .lock_q      (lock_status),
        .rd_offset   (rd_offset),
        .array_rdata (array_rdata),
        .rd_data     (rd_data)
    );

    assign prog_req         = pulse_q[0];
    assign chip_erase_req   = pulse_q[1];
    assign sector_erase_req = pulse_q[2];
    assign lock_req         = pulse_q[3];

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import flash_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              busy,
    input seq_state_e        seq_state,
    input logic              prog_req,
    input logic              chip_erase_req,
    input logic              sector_erase_req,
    input logic              lock_req,
    input logic [SECT_W-1:0] req_sector,
    input logic              id_mode,
    input logic              lock_status
);

    logic any_req;
    assign any_req = prog_req | chip_erase_req | sector_erase_req | lock_req;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lock_status && !id_mode && !any_req));

    // R11
    req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_req, chip_erase_req, sector_erase_req, lock_req}));

    // R11
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        any_req |=> !any_req);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || busy) |=> ($stable(seq_state) && !any_req));

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_status |=> lock_status);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_status) |-> lock_req);

    // R6
    boot_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (sector_erase_req && req_sector == SEC_BOOT) |-> !lock_status);

    // R8
    launch_leaves_id_chk: assert property (@(posedge clk) disable iff (rst)
        any_req |-> !id_mode);

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .wr_en            (wr_en),
    .busy             (busy),
    .seq_state        (seq_state),
    .prog_req         (prog_req),
    .chip_erase_req   (chip_erase_req),
    .sector_erase_req (sector_erase_req),
    .lock_req         (lock_req),
    .req_sector       (req_sector),
    .id_mode          (id_mode),
    .lock_status      (lock_status)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic [1:0]  rd_offset = '0;
    logic [7:0]  array_rdata = '0;
    logic [7:0]  rd_data;
    logic        prog_req, chip_erase_req, sector_erase_req, lock_req;
    logic [17:0] req_addr;
    logic [7:0]  req_data;
    logic [2:0]  req_sector;
    logic        id_mode, lock_status;

    always #10 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_offset(rd_offset), .array_rdata(array_rdata), .rd_data(rd_data),
        .prog_req(prog_req), .chip_erase_req(chip_erase_req),
        .sector_erase_req(sector_erase_req), .lock_req(lock_req),
        .req_addr(req_addr), .req_data(req_data), .req_sector(req_sector),
        .id_mode(id_mode), .lock_status(lock_status)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string tag     = "R1";
    int    m_st    = 0;
    bit    m_id    = 0;
    bit    m_lock  = 0;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] sect_idx(input logic [17:0] a);
        if (a >= 18'h3C000)      return 3'd4;
        else if (a >= 18'h3A000) return 3'd3;
        else if (a >= 18'h38000) return 3'd2;
        else if (a >= 18'h20000) return 3'd1;
        else                     return 3'd0;
    endfunction

    // reference model: returns 0 none, 1 program, 2 chip, 3 sector, 4 lock
    task automatic model(input logic [17:0] a, input logic [7:0] d, input bit b, output int ev);
        bit ha, hb;
        ev = 0;
        ha = (a[14:0] == 15'h5555);
        hb = (a[14:0] == 15'h2AAA);
        if (b) return;
        case (m_st)
            0: if (ha && d == 8'hAA) m_st = 1; else begin m_st = 0; m_id = 0; end
            1: if (hb && d == 8'h55) m_st = 2; else begin m_st = 0; m_id = 0; end
            2: begin
                if (ha && d == 8'hA0) m_st = 3;
                else if (ha && d == 8'h80) m_st = 4;
                else begin m_st = 0; m_id = (ha && d == 8'h90); end
            end
            3: begin ev = 1; m_st = 0; m_id = 0; end
            4: if (ha && d == 8'hAA) m_st = 5; else begin m_st = 0; m_id = 0; end
            5: if (hb && d == 8'h55) m_st = 6; else begin m_st = 0; m_id = 0; end
            default: begin
                m_st = 0; m_id = 0;
                if (d == 8'h30) begin
                    if (!(sect_idx(a) == 3'd4 && m_lock)) ev = 3;
                end else if (ha && d == 8'h10) ev = 2;
                else if (ha && d == 8'h40) begin ev = 4; m_lock = 1; end
            end
        endcase
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d, input bit b = 0);
        int ev;
        logic [3:0] expv;
        model(a, d, b, ev);
        expv = (ev == 1) ? 4'b1000 : (ev == 2) ? 4'b0100 :
               (ev == 3) ? 4'b0010 : (ev == 4) ? 4'b0001 : 4'b0000;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b;
        @(negedge clk);
        wr_en = 1'b0; busy = 1'b0;
        check("pulses", {prog_req, chip_erase_req, sector_erase_req, lock_req}, expv);
        if (ev != 0) begin
            check("req_addr", req_addr, a);
            check("req_data", req_data, d);
            check("req_sector", req_sector, sect_idx(a));
        end
        check("id_mode", id_mode, m_id);
        check("lock_status", lock_status, m_lock);
        if (ev != 0) begin
            @(negedge clk);
            // R11: pulse is gone one cycle later
            check("R11 pulse width", {prog_req, chip_erase_req, sector_erase_req, lock_req}, 4'b0);
        end
    endtask

    task automatic rdchk(input logic [1:0] off, input logic [7:0] arr);
        logic [7:0] exp;
        rd_offset = off; array_rdata = arr;
        #1;
        if (!m_id) exp = arr;
        else case (off)
            2'd0: exp = 8'hDA;
            2'd1: exp = 8'h0B;
            2'd2: exp = {7'b0, m_lock};
            default: exp = 8'h00;
        endcase
        check("rd_data", rd_data, exp);
    endtask

    task automatic unlk();
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55);
    endtask

    task automatic erase_pre();
        unlk(); wr(18'h05555, 8'h80); unlk();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_st = 0; m_id = 0; m_lock = 0;
        @(negedge clk);
        check("R1 pulses", {prog_req, chip_erase_req, sector_erase_req, lock_req}, 4'b0);
        check("R1 id_mode", id_mode, 1'b0);
        check("R1 lock", lock_status, 1'b0);
        rdchk(2'd0, 8'h5A);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [17:0] sa [6];
        logic [7:0]  sd [6];
        int          n;
        void'($urandom(32'd20240611));

        tag = "R1"; do_reset();

        tag = "R2"; // upper address bits do not matter in unlock compares
        wr(18'h3D555, 8'hAA); wr(18'h12AAA, 8'h55); wr(18'h25555, 8'hA0);
        wr(18'h1234A, 8'h5C);
        unlk(); wr(18'h05555, 8'hA0); wr(18'h3FFFF, 8'h00);

        tag = "R3"; erase_pre(); wr(18'h05555, 8'h10);

        tag = "R4";
        erase_pre(); wr(18'h00100, 8'h30);
        erase_pre(); wr(18'h2F000, 8'h30);
        erase_pre(); wr(18'h38010, 8'h30);
        erase_pre(); wr(18'h3BFFF, 8'h30);
        erase_pre(); wr(18'h3C000, 8'h30);

        tag = "R7";
        unlk(); wr(18'h05555, 8'h90);
        check("R7 id on", id_mode, 1'b1);
        rdchk(2'd0, 8'h11); rdchk(2'd1, 8'h22); rdchk(2'd2, 8'h33); rdchk(2'd3, 8'h44);

        tag = "R8";
        wr(18'h00123, 8'hF0);
        check("R8 single exit", id_mode, 1'b0);
        rdchk(2'd0, 8'h77);
        unlk(); wr(18'h05555, 8'h90);
        unlk(); wr(18'h05555, 8'hF0);
        check("R8 triple exit", id_mode, 1'b0);
        unlk(); wr(18'h05555, 8'h90);
        unlk(); wr(18'h05555, 8'hA0); wr(18'h00044, 8'h12);
        check("R8 exit on launch", id_mode, 1'b0);

        tag = "R9";
        unlk(); wr(18'h05555, 8'hA1); wr(18'h00200, 8'h99);
        wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00300, 8'h01);
        erase_pre(); wr(18'h05556, 8'h10);
        unlk(); wr(18'h05555, 8'h90); wr(18'h00000, 8'h12);
        check("R9 abort leaves id", id_mode, 1'b0);

        tag = "R10";
        wr(18'h05555, 8'hAA); wr(18'h05555, 8'h77, 1); wr(18'h02AAA, 8'h55);
        wr(18'h00000, 8'hF0, 1); wr(18'h05555, 8'hA0); wr(18'h01000, 8'h33, 1);
        wr(18'h01001, 8'h34);
        erase_pre(); wr(18'h05555, 8'h10, 1); wr(18'h05555, 8'h10);

        tag = "R5";
        erase_pre(); wr(18'h05555, 8'h40);
        check("R5 locked", lock_status, 1'b1);
        unlk(); wr(18'h05555, 8'h90);
        rdchk(2'd2, 8'h00);
        wr(18'h00000, 8'hF0);

        tag = "R6";
        erase_pre(); wr(18'h3E000, 8'h30);
        erase_pre(); wr(18'h3FFFF, 8'h30);
        erase_pre(); wr(18'h3A800, 8'h30);
        unlk(); wr(18'h05555, 8'hA0); wr(18'h3C001, 8'hAB);

        tag = "R5"; do_reset();
        check("R5 lock cleared by reset", lock_status, 1'b0);

        tag = "R9";
        for (int it = 0; it < 1500; it++) begin
            int k;
            k = $urandom_range(0, 7);
            sa[0] = {$urandom_range(0, 7), 15'h5555}; sd[0] = 8'hAA;
            sa[1] = {$urandom_range(0, 7), 15'h2AAA}; sd[1] = 8'h55;
            sa[2] = {$urandom_range(0, 7), 15'h5555};
            sa[3] = {$urandom_range(0, 7), 15'h5555}; sd[3] = 8'hAA;
            sa[4] = {$urandom_range(0, 7), 15'h2AAA}; sd[4] = 8'h55;
            sa[5] = {$urandom_range(0, 7), 15'h5555};
            sd[2] = 8'h80; n = 6;
            case (k)
                0: begin sd[2] = 8'hA0; sa[3] = 18'($urandom); sd[3] = 8'($urandom); n = 4; end
                1: sd[5] = 8'h10;
                2, 3: begin sa[5] = 18'($urandom); sd[5] = 8'h30; end
                4: sd[5] = 8'h40;
                5: begin sd[2] = 8'h90; n = 3; end
                6: begin sd[2] = 8'hF0; n = 3; end
                default: begin sa[0] = 18'($urandom); sd[0] = 8'hF0; n = 1; end
            endcase
            for (int j = 0; j < n; j++) begin
                if ($urandom_range(0, 9) == 0) wr(18'($urandom), 8'($urandom), 1);
                if ($urandom_range(0, 11) == 0) sd[j] = sd[j] ^ 8'($urandom_range(1, 255));
                wr(sa[j], sd[j]);
            end
            rdchk(2'($urandom), 8'($urandom));
            if (it % 300 == 299) do_reset();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule